// File: doc/BRIEF.md
# Selectable-Tap Timer Clock Prescaler

This block produces the count-enable pulse for an 8-bit timer. A free-running 10-bit prescaler advances once per source cycle, and a 3-bit divide code picks which tap drives the output. The code can stop the pulse, pass every source cycle through, or select one of six divided rates. The source cycle is one of two things. It is either every cycle of the main I/O clock, or each rising edge of a slow oscillator input such as a 32.768 kHz watch-crystal signal. In the second case the oscillator is brought into the I/O clock domain by a two-flop synchronizer and an edge detector, so the whole block runs on one clock.

Both configuration inputs, the source choice and the divide code, pass through a two-flop synchronizer before use. A one-cycle clear strobe zeroes the prescaler, so the first divided period after it has a known length. In oscillator mode the clear waits for the next oscillator-derived source cycle. The outputs are a registered single-cycle tick and the registered prescaler value.

Top module: `tpre_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pre_cnt` becomes 0 and `tick` becomes 0 at that edge.
- R2: With `src_osc` = 0 and no clear pending, `pre_cnt` rises by one at every clock edge and wraps from 1023 to 0. It keeps running for every divide code, including stop.
- R3: `div_sel` codes 010, 011, 100, 101, 110 and 111 divide by 8, 32, 64, 128, 256 and 1024. `tick` is high for exactly the one cycle in which `pre_cnt` has just advanced to a value that is a multiple of the selected divisor.
- R4: Code 000 (stop) keeps `tick` at 0.
- R5: Code 001 (undivided) raises `tick` on every source cycle in which the prescaler advances.
- R6: With `src_osc` = 1, `pre_cnt` advances only on the third rising clock edge after a rising edge of `osc_in`, counting from the first edge that samples `osc_in` high. At all other edges it holds.
- R7: A change of `src_osc` or `div_sel` first affects the outputs at the third rising clock edge after the edge that first samples the new value.
- R8: A `pre_clr` pulse makes the next source cycle set `pre_cnt` to 0 with `tick` low. In that cycle the clear wins over counting. With `src_osc` = 0 this happens at the very next edge.
- R9: With `src_osc` = 1, a `pre_clr` pulse is held pending and `pre_cnt` holds its value until the next oscillator-derived source cycle, which then sets it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | Asynchronous slow oscillator input |
| src_osc | input | 1 | Source choice: 0 = I/O clock, 1 = oscillator edges |
| div_sel | input | 3 | Divide code: 000 stop, 001 /1, 010 /8, 011 /32, 100 /64, 101 /128, 110 /256, 111 /1024 |
| pre_clr | input | 1 | One-cycle prescaler clear strobe |
| tick | output | 1 | Registered count-enable pulse, one cycle wide |
| pre_cnt | output | 10 | Registered prescaler value |

## Verification
A clear and a tap wrap can land on the same source cycle. The clear must win: the prescaler goes to zero and no tick appears, even though advancing would have produced a wrap. The bench provokes this in three ways: random clear strobes under the undivided code, a directed strobe in I/O mode, and a strobe held pending across oscillator edges. Each cycle it compares `pre_cnt` and `tick` against a bench model built from the stated synchronizer latencies and divisor arithmetic.

// File: rtl/tpre_pkg.sv
package tpre_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    DIV_STOP = 3'b000,
    DIV_1    = 3'b001,
    DIV_8    = 3'b010,
    DIV_32   = 3'b011,
    DIV_64   = 3'b100,
    DIV_128  = 3'b101,
    DIV_256  = 3'b110,
    DIV_1024 = 3'b111
  } div_code_e;

  // number of low prescaler bits that must wrap for a tick
  function automatic int tap_log(input logic [CODE_W-1:0] code);
    case (div_code_e'(code))
      DIV_1:    return 0;
      DIV_8:    return 3;
      DIV_32:   return 5;
      DIV_64:   return 6;
      DIV_128:  return 7;
      DIV_256:  return 8;
      DIV_1024: return 10;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/tpre_sync.sv
module tpre_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tpre_src_gate.sv
module tpre_src_gate #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_pin,
  input  logic use_osc,
  output logic src_en
);
  logic osc_s;
  logic osc_d;

  tpre_sync #(.W(1), .STAGES(STAGES)) u_osc_sync (
    .clk (clk),
    .rst (rst),
    .d   (osc_pin),
    .q   (osc_s)
  );

  always_ff @(posedge clk) begin
    if (rst) osc_d <= 1'b0;
    else     osc_d <= osc_s;
  end

  // one source cycle per I/O clock, or per synchronized oscillator rise
  assign src_en = use_osc ? (osc_s & ~osc_d) : 1'b1;
endmodule

// File: rtl/tpre_counter.sv
module tpre_counter
  import tpre_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                src_en,
  input  logic                clr_strobe,
  input  logic [CODE_W-1:0]   sel,
  output logic [PRE_W-1:0]    cnt_q,
  output logic                tick_q,
  output logic                clr_apply
);
  logic             clr_pend;
  logic             clr_req;
  logic [PRE_W-1:0] nxt;
  logic [PRE_W-1:0] mask;
  logic             wrap;

  assign clr_req   = clr_strobe | clr_pend;
  assign clr_apply = src_en & clr_req;
  assign nxt       = cnt_q + 1'b1;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < tap_log(sel));
  end

  assign wrap = ((nxt & mask) == '0) && (sel != DIV_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      tick_q   <= 1'b0;
      clr_pend <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (src_en) begin
        clr_pend <= 1'b0;
        if (clr_req) begin
          cnt_q <= '0;
        end else begin
          cnt_q  <= nxt;
          tick_q <= wrap;
        end
      end else begin
        clr_pend <= clr_req;
      end
    end
  end
endmodule

// File: rtl/tpre_top.sv
module tpre_top
  import tpre_pkg::*;
#(
  parameter int PRE_W  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_in,
  input  logic             src_osc,
  input  logic [2:0]       div_sel,
  input  logic             pre_clr,
  output logic             tick,
  output logic [PRE_W-1:0] pre_cnt
);
  localparam int CFG_W = CODE_W + 1;

  logic [CFG_W-1:0] cfg_s;
  logic             src_en;
  logic             clr_apply;

  tpre_sync #(.W(CFG_W), .STAGES(STAGES)) u_cfg_sync (
    .clk (clk),
    .rst (rst),
    .d   ({src_osc, div_sel}),
    .q   (cfg_s)
  );

  tpre_src_gate #(.STAGES(STAGES)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .osc_pin (osc_in),
    .use_osc (cfg_s[CODE_W]),
    .src_en  (src_en)
  );

  tpre_counter #(.PRE_W(PRE_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .src_en     (src_en),
    .clr_strobe (pre_clr),
    .sel        (cfg_s[CODE_W-1:0]),
    .cnt_q      (pre_cnt),
    .tick_q     (tick),
    .clr_apply  (clr_apply)
  );
endmodule

// File: rtl/tpre_checker.sv
module tpre_checker #(
  parameter int PRE_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [3:0]       cfg_s,
  input logic             src_en,
  input logic             clr_apply
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pre_cnt == '0 && !tick));

  // R2
  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    (pre_cnt != $past(pre_cnt)) |-> (pre_cnt == PRE_W'($past(pre_cnt) + 1'b1) || pre_cnt == '0));

  // R6
  a_r6_hold_without_source: assert property (@(posedge clk) disable iff (rst)
    !$past(src_en) |-> $stable(pre_cnt));

  // R3
  a_r3_tick_on_advance: assert property (@(posedge clk) disable iff (rst)
    tick |-> (pre_cnt == PRE_W'($past(pre_cnt) + 1'b1)));

  // R4
  a_r4_stop_silent: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_s[2:0]) == 3'b000) |-> !tick);

  // R8
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    $past(clr_apply) |-> (pre_cnt == '0 && !tick));
endmodule

bind tpre_top tpre_checker #(.PRE_W(PRE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .pre_cnt   (pre_cnt),
  .cfg_s     (cfg_s),
  .src_en    (src_en),
  .clr_apply (clr_apply)
);

// File: tb/tb_tpre_top.sv
module tb_tpre_top;
  localparam int PRE_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             osc_in = 1'b0;
  logic             src_osc = 1'b0;
  logic [2:0]       div_sel = 3'd0;
  logic             pre_clr = 1'b0;
  logic             tick;
  logic [PRE_W-1:0] pre_cnt;

  int total = 0, bad = 0;
  int osc_half = 4, osc_cnt = 0, clr_pct = 0, cfg_age = 100;
  bit osc_run = 0, cmp_on = 0, done = 0;

  always #4 clk = ~clk;

  tpre_top dut (
    .clk(clk), .rst(rst), .osc_in(osc_in), .src_osc(src_osc),
    .div_sel(div_sel), .pre_clr(pre_clr), .tick(tick), .pre_cnt(pre_cnt)
  );

  function automatic int divisor(input logic [2:0] code);
    case (code)
      3'd1: return 1;    3'd2: return 8;   3'd3: return 32;
      3'd4: return 64;   3'd5: return 128; 3'd6: return 256;
      3'd7: return 1024; default: return 0;
    endcase
  endfunction

  // bench model built from stated latencies
  logic [3:0]       mc1, mc2;
  logic             mo1, mo2, mo3, m_pend, m_tick, m_hit;
  logic [PRE_W-1:0] m_cnt;

  always @(posedge clk) begin : model
    logic en, req;
    logic [PRE_W-1:0] n;
    if (rst) begin
      mc1 <= '0; mc2 <= '0; mo1 <= 0; mo2 <= 0; mo3 <= 0;
      m_pend <= 0; m_tick <= 0; m_hit <= 0; m_cnt <= '0;
    end else begin
      mc1 <= {src_osc, div_sel}; mc2 <= mc1;
      mo1 <= osc_in; mo2 <= mo1; mo3 <= mo2;
      en  = mc2[3] ? (mo2 & !mo3) : 1'b1;
      req = pre_clr | m_pend;
      n   = m_cnt + 1'b1;
      m_tick <= 0;
      m_hit  <= en & req;
      if (en) begin
        m_pend <= 0;
        if (req) m_cnt <= '0;
        else begin
          m_cnt  <= n;
          m_tick <= (mc2[2:0] != 3'd0) && ((int'(n) % divisor(mc2[2:0])) == 0);
        end
      end else m_pend <= req;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      string ct, tt;
      if (cfg_age < 4)  ct = "R7";
      else if (m_hit)   ct = mc2[3] ? "R9" : "R8";
      else              ct = mc2[3] ? "R6" : "R2";
      if (cfg_age < 4)            tt = "R7";
      else if (m_hit)             tt = "R8";
      else if (mc2[2:0] == 3'd0)  tt = "R4";
      else if (mc2[2:0] == 3'd1)  tt = "R5";
      else                        tt = "R3";
      chk(pre_cnt == m_cnt, ct, int'(pre_cnt), int'(m_cnt));
      chk(tick == m_tick, tt, int'(tick), int'(m_tick));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pre_clr = ($urandom_range(99) < clr_pct);
      if (osc_run) begin
        if (osc_cnt == 0) begin
          osc_in  = ~osc_in;
          osc_cnt = $urandom_range(osc_half + 2, osc_half);
        end else osc_cnt--;
      end
      cfg_age++;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(pre_cnt == '0, "R1", int'(pre_cnt), 0);
    chk(tick == 1'b0, "R1", int'(tick), 0);
    rst = 1'b0;
    cmp_on = 1;

    // every code in I/O mode, long enough for a full wrap
    for (int c = 0; c < 8; c++) begin
      div_sel = 3'(c); cfg_age = 0;
      step(1100);
    end

    // directed clear under the undivided code
    div_sel = 3'd1; cfg_age = 0;
    step(10);
    pre_clr = 1'b1;
    @(negedge clk);
    chk(pre_cnt == '0, "R8", int'(pre_cnt), 0);
    chk(tick == 1'b0, "R8", int'(tick), 0);
    pre_clr = 1'b0;

    // random clears in I/O mode
    clr_pct = 3; div_sel = 3'd2; cfg_age = 0;
    step(2000);

    // oscillator mode
    src_osc = 1; osc_run = 1; osc_half = 3; clr_pct = 2;
    div_sel = 3'd2; cfg_age = 0;
    step(3000);
    div_sel = 3'd1; cfg_age = 0;
    step(500);

    // directed pending clear in oscillator mode
    osc_run = 0; clr_pct = 0; osc_in = 1'b0;
    step(6);
    begin
      logic [PRE_W-1:0] held;
      held = pre_cnt;
      pre_clr = 1'b1;
      @(negedge clk);
      pre_clr = 1'b0;
      step(5);
      chk(pre_cnt == held, "R9", int'(pre_cnt), int'(held));
      osc_in = 1'b1;
      step(4);
      chk(pre_cnt == '0, "R9", int'(pre_cnt), 0);
    end

    // random mix of configurations
    osc_run = 1;
    for (int k = 0; k < 40; k++) begin
      src_osc  = 1'($urandom_range(1));
      div_sel  = 3'($urandom_range(7));
      osc_half = $urandom_range(6, 2);
      clr_pct  = $urandom_range(5);
      cfg_age  = 0;
      step($urandom_range(1500, 200));
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule